// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is the descriptor engine of a single DMA channel. Software gives it the address of a list of 8-byte descriptors held in memory and pulses a start input. The walker reads each descriptor over a simple read port that takes a request and returns one response, decodes a buffer address and a byte length from it, and hands that pair to a downstream data mover as a one-cycle segment command. It then waits until the mover reports that the segment is finished.

Descriptors sit back to back in memory, so each one follows the previous one at the next 8-byte step. The chain ends at the descriptor whose end flag is set, not at a null pointer. When that last segment finishes, the walker emits a one-cycle completion strobe, which the channel's interrupt status bit picks up. A malformed descriptor ends the chain with an error strobe. An abort input, or dropping the enable while the channel runs in the receive direction, ends the chain early and raises no completion.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset the walker is idle. `busy`, `rd_req`, `seg_valid`, `done` and `err` are all low.
- R2: A start pulse while idle fetches the descriptor at `list_addr` as two 32-bit reads: first the low word at `list_addr`, then the high word at `list_addr+4`. The second request is raised only after the first response returns, and `rd_addr` stays stable while a request waits for its response.
- R3: Low word layout: bit 0 is valid, bit 1 is last, bit 5 is transfer, bits 15:8 are zero, and bits 31:16 are the byte length. The high word is the 32-bit buffer address. One cycle after the high-word response, `seg_valid` pulses for one cycle carrying that address and length.
- R4: A descriptor with the valid bit clear, or with length bits 1:0 not zero, raises `err` for one cycle one cycle after its high-word response. It issues no segment command and returns the walker to idle.
- R5: When `seg_done` arrives and the descriptor is not last, the next fetch starts at the current descriptor address plus 8. When the descriptor is last, `done` pulses for one cycle in the cycle after `seg_done` and the walker goes idle.
- R6: A start pulse while `busy` is high has no effect on the fetch addresses or on the chain in progress.
- R7: An abort pulse while busy is held until the pending read response or `seg_done` arrives. The walker then goes idle without any further read, segment command or `done`. This includes an abort that falls in the same cycle as `seg_done`.
- R8: In receive mode (`rx_mode`=1, sampled at start), `enable` low while busy acts as an abort. In transmit mode `enable` is ignored.
- R9: `done` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; acted on only when idle |
| list_addr | input | 32 | Byte address of the first descriptor |
| rx_mode | input | 1 | 1 = receive direction, sampled at start |
| enable | input | 1 | Receive enable; low stops a receive chain |
| abort | input | 1 | Stop request pulse |
| rd_req | output | 1 | Read request, held until `rd_rvalid` |
| rd_addr | output | 32 | Read word address (byte address) |
| rd_rvalid | input | 1 | Read response strobe |
| rd_rdata | input | 32 | Read response data |
| seg_valid | output | 1 | One-cycle segment command strobe |
| seg_addr | output | 32 | Segment buffer address |
| seg_len | output | 16 | Segment byte length |
| seg_done | input | 1 | Mover finished the current segment |
| busy | output | 1 | Walker is not idle |
| done | output | 1 | One-cycle chain completion strobe |
| err | output | 1 | One-cycle malformed-descriptor strobe |

## Verification
Two events can land on the same clock edge. The first pair is a stop request (abort or a dropped receive enable) and the mover's `seg_done` for a descriptor that is not last. The bench's mover model raises `seg_done` and `abort` on the same edge. It then expects no further read request, no `done` and a return to idle, since a missing stop would continue the chain to the next address. The second pair is a start pulse and a chain already in progress. The bench pulses start with a different list address mid-chain. Its read-address scoreboard shows that every fetch still follows the original chain.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 8;
    localparam int HI_OFFSET  = 4;
    // low descriptor word field positions
    localparam int BIT_VALID  = 0;
    localparam int BIT_LAST   = 1;
    localparam int BIT_XFER   = 5;
    localparam int LEN_LSB    = 16;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LO   = 2'd1,
        S_HI   = 2'd2,
        S_RUN  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
    import sgw_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic [WORD_W-1:0] lo_word,
    output logic              f_ok,
    output logic              f_last,
    output logic [LEN_W-1:0]  f_len
);
    logic aligned;

    always_comb begin
        f_len   = lo_word[LEN_LSB +: LEN_W];
        f_last  = lo_word[BIT_LAST];
        aligned = (f_len[ALIGN_BITS-1:0] == '0);
        f_ok    = lo_word[BIT_VALID] & aligned;
    end
endmodule

// File: rtl/sgw_walk_fsm.sv
module sgw_walk_fsm
    import sgw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     list_addr,
    input  logic              rx_mode,
    input  logic              enable,
    input  logic              abort,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_rvalid,
    input  logic [WORD_W-1:0] rd_rdata,
    output logic              seg_valid,
    output logic [AW-1:0]     seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    input  logic              seg_done,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] lo_word,
    input  logic              f_ok,
    input  logic              f_last,
    input  logic [LEN_W-1:0]  f_len
);
    localparam logic [AW-1:0] STEP  = AW'(DESC_BYTES);
    localparam logic [AW-1:0] HI_OF = AW'(HI_OFFSET);

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     ptr;
        logic [WORD_W-1:0] lo;
        logic              rx;
        logic              stop;
        logic              last;
        logic              seg_v;
        logic [AW-1:0]     seg_a;
        logic [LEN_W-1:0]  seg_l;
        logic              done;
        logic              err;
    } walk_t;

    walk_t w_d, w_q;
    logic  stop_now;

    always_comb begin
        w_d       = w_q;
        w_d.seg_v = 1'b0;
        w_d.done  = 1'b0;
        w_d.err   = 1'b0;
        stop_now  = w_q.stop | abort | (w_q.rx & ~enable);
        case (w_q.st)
            S_IDLE: begin
                if (start) begin
                    w_d.st   = S_LO;
                    w_d.ptr  = list_addr;
                    w_d.rx   = rx_mode;
                    w_d.stop = 1'b0;
                end
            end
            S_LO: begin
                w_d.stop = stop_now;
                if (rd_rvalid) begin
                    w_d.lo = rd_rdata;
                    w_d.st = stop_now ? S_IDLE : S_HI;
                end
            end
            S_HI: begin
                w_d.stop = stop_now;
                if (rd_rvalid) begin
                    if (stop_now) begin
                        w_d.st = S_IDLE;
                    end else if (!f_ok) begin
                        w_d.err = 1'b1;
                        w_d.st  = S_IDLE;
                    end else begin
                        w_d.seg_v = 1'b1;
                        w_d.seg_a = rd_rdata;
                        w_d.seg_l = f_len;
                        w_d.last  = f_last;
                        w_d.st    = S_RUN;
                    end
                end
            end
            default: begin
                w_d.stop = stop_now;
                if (seg_done) begin
                    if (stop_now) begin
                        w_d.st = S_IDLE;
                    end else if (w_q.last) begin
                        w_d.done = 1'b1;
                        w_d.st   = S_IDLE;
                    end else begin
                        w_d.ptr = w_q.ptr + STEP;
                        w_d.st  = S_LO;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: S_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    always_comb begin
        rd_req    = (w_q.st == S_LO) || (w_q.st == S_HI);
        rd_addr   = (w_q.st == S_HI) ? (w_q.ptr + HI_OF) : w_q.ptr;
        seg_valid = w_q.seg_v;
        seg_addr  = w_q.seg_a;
        seg_len   = w_q.seg_l;
        busy      = (w_q.st != S_IDLE);
        done      = w_q.done;
        err       = w_q.err;
        lo_word   = w_q.lo;
    end

    // R2: a waiting request keeps its address until answered
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_rvalid |=> rd_req && $stable(rd_addr));
    // R3: a segment command follows a read response
    p_seg_after_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> $past(rd_rvalid));
    // R4: no misaligned segment leaves the walker
    p_seg_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len[1:0] == 2'b00));
    // R5: completion only after the mover finished
    p_done_after_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(seg_done) && !$past(abort));
    // R6: a start while working does not end the chain
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !rd_rvalid && !seg_done |=> busy);
    // R7: an abort never lets a segment out
    p_abort_no_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !$past(abort));
    // R9: completion and error are exclusive
    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LEN_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     list_addr,
    input  logic              rx_mode,
    input  logic              enable,
    input  logic              abort,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_rvalid,
    input  logic [WORD_W-1:0] rd_rdata,
    output logic              seg_valid,
    output logic [AW-1:0]     seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    input  logic              seg_done,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic [WORD_W-1:0] lo_word;
    logic              f_ok;
    logic              f_last;
    logic [LEN_W-1:0]  f_len;

    sgw_desc_decode #(.LEN_W(LEN_W), .ALIGN_BITS(ALIGN_BITS)) i_dec (
        .lo_word (lo_word),
        .f_ok    (f_ok),
        .f_last  (f_last),
        .f_len   (f_len)
    );

    sgw_walk_fsm #(.AW(AW), .LEN_W(LEN_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .list_addr (list_addr),
        .rx_mode   (rx_mode),
        .enable    (enable),
        .abort     (abort),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_rvalid (rd_rvalid),
        .rd_rdata  (rd_rdata),
        .seg_valid (seg_valid),
        .seg_addr  (seg_addr),
        .seg_len   (seg_len),
        .seg_done  (seg_done),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .lo_word   (lo_word),
        .f_ok      (f_ok),
        .f_last    (f_last),
        .f_len     (f_len)
    );
endmodule

// File: tb/test_sg_chain_walker.sv
module test_sg_chain_walker;
    localparam int RD_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] list_addr = '0;
    logic        rx_mode = 1'b0;
    logic        enable = 1'b1;
    logic        abort_tb = 1'b0;
    logic        abort_mv = 1'b0;
    logic        abort;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_rvalid = 1'b0;
    logic [31:0] rd_rdata = '0;
    logic        seg_valid;
    logic [31:0] seg_addr;
    logic [15:0] seg_len;
    logic        seg_done = 1'b0;
    logic        busy, done, err;

    assign abort = abort_tb | abort_mv;

    always #10 clk = ~clk;   // 50 MHz

    sg_chain_walker i_sg_chain_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .list_addr(list_addr),
        .rx_mode(rx_mode), .enable(enable), .abort(abort),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
        .rd_rdata(rd_rdata), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_done(seg_done), .busy(busy),
        .done(done), .err(err)
    );

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int seg_cnt = 0;
    int mv_lat = 4;
    bit abort_at_done = 0;
    logic [31:0] mem [0:255];
    logic [31:0] exp_rd[$];
    logic [47:0] exp_seg[$];

    task automatic check(input bit ok, input string tag,
                         input logic [47:0] act, input logic [47:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    // descriptor writer: flags byte = transfer | valid | last<<1
    task automatic put_desc(input logic [31:0] a, input bit vld, input bit lst,
                            input logic [15:0] len, input logic [31:0] buf_a);
        mem[a[9:2]]     = {len, 8'h00, 8'h20 | {6'b0, lst, vld}};
        mem[a[9:2] + 1] = buf_a;
    endtask

    task automatic expect_fetch(input logic [31:0] a);
        exp_rd.push_back(a);
        exp_rd.push_back(a + 32'd4);
    endtask

    task automatic kick(input logic [31:0] a, input bit rx);
        @(negedge clk);
        start = 1'b1; list_addr = a; rx_mode = rx;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        check(exp_rd.size() == 0, {tag, " reads left"}, exp_rd.size(), 0);
        check(exp_seg.size() == 0, {tag, " segments left"}, exp_seg.size(), 0);
        check(!busy, {tag, " idle"}, busy, 0);
    endtask

    // read responder and read-address scoreboard
    int rd_cnt = 0;
    always @(negedge clk) begin
        if (rd_rvalid) begin
            rd_rvalid = 1'b0;
            rd_cnt = 0;
        end else if (rd_req && rst_n) begin
            rd_cnt++;
            if (rd_cnt == RD_LAT) begin
                rd_rvalid = 1'b1;
                rd_rdata = mem[rd_addr[9:2]];
                if (exp_rd.size() == 0) begin
                    check(1'b0, "R2 unexpected read", {16'h0, rd_addr}, 48'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    check(rd_addr == e, "R2 read address", {16'h0, rd_addr}, {16'h0, e});
                end
            end
        end
    end

    // mover model and segment scoreboard
    int mv_cnt = 0;
    bit mv_busy = 0;
    always @(negedge clk) begin
        abort_mv = 1'b0;
        seg_done = 1'b0;
        if (done) done_cnt++;
        if (err) err_cnt++;
        if (done && err) check(1'b0, "R9 done with err", 1, 0);
        if (seg_valid) begin
            seg_cnt++;
            if (exp_seg.size() == 0) begin
                check(1'b0, "R3 unexpected segment", {seg_len, seg_addr}, 48'h0);
            end else begin
                logic [47:0] e;
                e = exp_seg.pop_front();
                check({seg_len, seg_addr} == e, "R3 segment", {seg_len, seg_addr}, e);
            end
            mv_cnt = mv_lat;
            mv_busy = 1;
        end else if (mv_busy) begin
            if (mv_cnt <= 1) begin
                seg_done = 1'b1;
                mv_busy = 0;
                if (abort_at_done) begin
                    abort_mv = 1'b1;
                    abort_at_done = 0;
                end
            end else begin
                mv_cnt--;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0, e0, s0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !rd_req && !seg_valid && !done && !err, "R1 reset outputs",
              {busy, rd_req, seg_valid, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !rd_req, "R1 idle after reset", {busy, rd_req}, 0);

        // R2 R3 R5: three-descriptor chain
        put_desc(32'h040, 1, 0, 16'h0010, 32'h1000_0000);
        put_desc(32'h048, 1, 0, 16'h0004, 32'h2000_0040);
        put_desc(32'h050, 1, 1, 16'h0100, 32'h3000_0100);
        expect_fetch(32'h040); expect_fetch(32'h048); expect_fetch(32'h050);
        exp_seg.push_back({16'h0010, 32'h1000_0000});
        exp_seg.push_back({16'h0004, 32'h2000_0040});
        exp_seg.push_back({16'h0100, 32'h3000_0100});
        d0 = done_cnt; e0 = err_cnt;
        kick(32'h040, 0);
        wait_idle();
        check(done_cnt == d0 + 1, "R5 one done for chain", done_cnt - d0, 1);
        check(err_cnt == e0, "R5 no err for chain", err_cnt - e0, 0);
        drain("R5 chain");

        // R3: largest aligned length, single last descriptor
        put_desc(32'h080, 1, 1, 16'hFFFC, 32'hDEAD_BEE0);
        expect_fetch(32'h080);
        exp_seg.push_back({16'hFFFC, 32'hDEAD_BEE0});
        d0 = done_cnt;
        kick(32'h080, 0);
        wait_idle();
        check(done_cnt == d0 + 1, "R3 max length done", done_cnt - d0, 1);
        drain("R3 max length");

        // R4: second descriptor has valid clear
        put_desc(32'h0C0, 1, 0, 16'h0008, 32'h0000_4000);
        put_desc(32'h0C8, 0, 1, 16'h0008, 32'h0000_5000);
        expect_fetch(32'h0C0); expect_fetch(32'h0C8);
        exp_seg.push_back({16'h0008, 32'h0000_4000});
        d0 = done_cnt; e0 = err_cnt;
        kick(32'h0C0, 0);
        wait_idle();
        check(err_cnt == e0 + 1, "R4 invalid flag err", err_cnt - e0, 1);
        check(done_cnt == d0, "R4 invalid no done", done_cnt - d0, 0);
        drain("R4 invalid");

        // R4: misaligned length on first descriptor
        put_desc(32'h100, 1, 1, 16'h0006, 32'h0000_6000);
        expect_fetch(32'h100);
        s0 = seg_cnt; e0 = err_cnt;
        kick(32'h100, 0);
        wait_idle();
        check(err_cnt == e0 + 1, "R4 misaligned err", err_cnt - e0, 1);
        check(seg_cnt == s0, "R4 misaligned no segment", seg_cnt - s0, 0);
        drain("R4 misaligned");

        // R6: start while busy is ignored
        put_desc(32'h140, 1, 0, 16'h0020, 32'h0000_7000);
        put_desc(32'h148, 1, 1, 16'h0024, 32'h0000_8000);
        expect_fetch(32'h140); expect_fetch(32'h148);
        exp_seg.push_back({16'h0020, 32'h0000_7000});
        exp_seg.push_back({16'h0024, 32'h0000_8000});
        d0 = done_cnt;
        kick(32'h140, 0);
        repeat (6) @(negedge clk);
        start = 1'b1; list_addr = 32'h200;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(done_cnt == d0 + 1, "R6 chain unaffected", done_cnt - d0, 1);
        drain("R6 start busy");

        // R7: abort while the low-word read is pending
        put_desc(32'h180, 1, 1, 16'h0010, 32'h0000_9000);
        exp_rd.push_back(32'h180);
        d0 = done_cnt; s0 = seg_cnt;
        kick(32'h180, 0);
        abort_tb = 1'b1;
        @(negedge clk);
        abort_tb = 1'b0;
        wait_idle();
        check(done_cnt == d0 && seg_cnt == s0, "R7 abort in fetch",
              {done_cnt - d0, seg_cnt - s0}, 0);
        drain("R7 abort fetch");

        // R7: abort on the same edge as seg_done of a non-last descriptor
        put_desc(32'h1C0, 1, 0, 16'h0010, 32'h0000_A000);
        put_desc(32'h1C8, 1, 1, 16'h0010, 32'h0000_B000);
        expect_fetch(32'h1C0);
        exp_seg.push_back({16'h0010, 32'h0000_A000});
        abort_at_done = 1;
        d0 = done_cnt;
        kick(32'h1C0, 0);
        wait_idle();
        check(done_cnt == d0, "R7 abort with seg_done no done", done_cnt - d0, 0);
        drain("R7 abort coincident");

        // R8: receive mode, enable drops during a segment
        put_desc(32'h240, 1, 0, 16'h0040, 32'h0000_C000);
        put_desc(32'h248, 1, 1, 16'h0040, 32'h0000_D000);
        expect_fetch(32'h240);
        exp_seg.push_back({16'h0040, 32'h0000_C000});
        mv_lat = 12;
        d0 = done_cnt;
        kick(32'h240, 1);
        while (!seg_valid) @(negedge clk);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        wait_idle();
        enable = 1'b1;
        check(done_cnt == d0, "R8 rx enable low stops", done_cnt - d0, 0);
        drain("R8 rx stop");

        // R8: transmit mode ignores enable
        put_desc(32'h280, 1, 0, 16'h0008, 32'h0000_E000);
        put_desc(32'h288, 1, 1, 16'h000C, 32'h0000_F000);
        expect_fetch(32'h280); expect_fetch(32'h288);
        exp_seg.push_back({16'h0008, 32'h0000_E000});
        exp_seg.push_back({16'h000C, 32'h0000_F000});
        mv_lat = 3;
        enable = 1'b0;
        d0 = done_cnt;
        kick(32'h280, 0);
        wait_idle();
        enable = 1'b1;
        check(done_cnt == d0 + 1, "R8 tx ignores enable", done_cnt - d0, 1);
        drain("R8 tx");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule